// File: doc/BRIEF.md
# Trap Value Selection Unit

When the core takes a trap, this block picks the value written into the trap value register and the exception PC. It also picks which privilege copy (machine, supervisor or virtual-supervisor) gets the write. The inputs are the trap cause, the interrupt flag, the target level and the faulting PC. The block also takes the load/store/atomic effective address, a data-address trigger hit and the raw instruction bits, together with a flag that marks a compressed encoding.

The block also watches every jump, branch and CSR-produced target. Such a target is invalid when any bit above the supported address width is set. The block flags it, and it keeps the first such target in full in one held register. Truncation would lose the bits that made the target invalid. When the fetch trap for that target arrives, the held value is written as both the trap value and the exception PC.

Each trap is taken in one cycle with `trap_fire` high. The chosen values and write strobes appear on registered outputs in the next cycle, as a single-cycle pulse.

Top module: `trap_value_sel`

## Requirements
- R1: `tgt_bad` is high in the same cycle whenever `tgt_valid` is high and any bit of `tgt_addr` at position VAW or above is set. When no target is held, such a target is captured in full into the held register. Targets with those high bits clear are never captured.
- R2: While a target is held, later invalid targets do not replace it. The held register is released by any cycle with `trap_fire` high, and no capture happens in that cycle.
- R3: For a bad-target fetch trap (cause code 1, not an interrupt), `out_tval` and `out_epc` both equal the held full target. If no target is held, both equal `pc`.
- R4: A trigger breakpoint is taken when `trig_hit` is high on an exception whose cause is 0. It reports `out_cause` = 9 and `out_tval` = `mem_addr`.
- R5: On an atomic access (`is_amo` high), `trig_hit` wins over a misaligned cause (3 = load, 4 = store) and yields the breakpoint of R4. On a non-atomic access the misaligned cause is kept.
- R6: For an illegal instruction (cause 2) with `inst_rvc` high, `out_tval` is `inst[15:0]` zero-extended.
- R7: For an illegal instruction (cause 2) with `inst_rvc` low, `out_tval` is `inst[31:0]` zero-extended to XLEN.
- R8: For an interrupt (`trap_intr` high), `out_tval` is zero, `out_epc` is `pc` and `out_cause` is `trap_cause`.
- R9: For load/store misaligned or access fault (causes 3, 4, 5, 6), `out_tval` is the full `mem_addr`, high bits included. For a fetch access fault (cause 8), `out_tval` is `pc`.
- R10: Every other cause, environment calls included, gives `out_tval` = 0.
- R11: Exactly one write strobe pulses in the cycle after `trap_fire`, chosen by `trap_lvl`: 1 = supervisor, 2 = virtual-supervisor, 0 or 3 = machine. All strobes are low after reset and in every other cycle.
- R12: For every trap except R3, `out_epc` is `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_valid | input | 1 | A jump/branch/CSR target is presented |
| tgt_addr | input | XLEN | The presented target |
| tgt_bad | output | 1 | Presented target exceeds the address width |
| trap_fire | input | 1 | A trap is taken this cycle |
| trap_intr | input | 1 | The trap is an interrupt |
| trap_cause | input | CW | Cause code |
| trap_lvl | input | 2 | Target level: 0/3 machine, 1 supervisor, 2 virtual-supervisor |
| is_amo | input | 1 | The memory access is atomic |
| trig_hit | input | 1 | Data-address trigger fired |
| pc | input | XLEN | Faulting PC |
| mem_addr | input | XLEN | Full effective data address |
| inst | input | 32 | Raw instruction bits |
| inst_rvc | input | 1 | Instruction is a 16-bit compressed encoding |
| out_we_m | output | 1 | Machine copy write strobe |
| out_we_s | output | 1 | Supervisor copy write strobe |
| out_we_vs | output | 1 | Virtual-supervisor copy write strobe |
| out_cause | output | CW | Final cause after breakpoint priority |
| out_tval | output | XLEN | Chosen trap value |
| out_epc | output | XLEN | Chosen exception PC |

## Verification
The block's only internal state is the held target and its valid flag. If that state is wrong, nothing shows at the ports until the next bad-target fetch trap. Then `out_tval` and `out_epc` are wrong together, one cycle after `trap_fire`. A lost capture shows as `pc`, and a wrongful overwrite shows as a younger target. For this reason the sweep arms the register with an older target and then a younger one before every trap. Wrong breakpoint priority or a wrong instruction-width choice shows in the same cycle as a wrong `out_cause` or `out_tval`.

// File: rtl/trap_value_sel.sv
module trap_value_sel #(
  parameter int XLEN = 64,
  parameter int VAW  = 39,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tgt_valid,
  input  logic [XLEN-1:0] tgt_addr,
  output logic            tgt_bad,
  input  logic            trap_fire,
  input  logic            trap_intr,
  input  logic [CW-1:0]   trap_cause,
  input  logic [1:0]      trap_lvl,
  input  logic            is_amo,
  input  logic            trig_hit,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] mem_addr,
  input  logic [31:0]     inst,
  input  logic            inst_rvc,
  output logic            out_we_m,
  output logic            out_we_s,
  output logic            out_we_vs,
  output logic [CW-1:0]   out_cause,
  output logic [XLEN-1:0] out_tval,
  output logic [XLEN-1:0] out_epc
);
  localparam logic [CW-1:0] C_NONE    = CW'(0);
  localparam logic [CW-1:0] C_BADTGT  = CW'(1);
  localparam logic [CW-1:0] C_ILL     = CW'(2);
  localparam logic [CW-1:0] C_LDMA    = CW'(3);
  localparam logic [CW-1:0] C_STMA    = CW'(4);
  localparam logic [CW-1:0] C_LDAF    = CW'(5);
  localparam logic [CW-1:0] C_STAF    = CW'(6);
  localparam logic [CW-1:0] C_FETCHAF = CW'(8);
  localparam logic [CW-1:0] C_BRK     = CW'(9);

  logic            held_vld;
  logic [XLEN-1:0] held_tgt;

  assign tgt_bad = tgt_valid && (|tgt_addr[XLEN-1:VAW]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_vld <= 1'b0;
      held_tgt <= '0;
    end else if (trap_fire) begin
      held_vld <= 1'b0;
    end else if (tgt_bad && !held_vld) begin
      held_vld <= 1'b1;
      held_tgt <= tgt_addr;
    end
  end

  logic            misal;
  logic            brk;
  logic [CW-1:0]   nx_cause;
  logic [XLEN-1:0] nx_tval;
  logic [XLEN-1:0] nx_epc;
  logic [XLEN-1:0] bad_pc;

  assign misal    = (trap_cause == C_LDMA) || (trap_cause == C_STMA);
  assign brk      = !trap_intr && trig_hit && ((trap_cause == C_NONE) || (is_amo && misal));
  assign nx_cause = brk ? C_BRK : trap_cause;
  assign bad_pc   = held_vld ? held_tgt : pc;

  always_comb begin
    nx_tval = '0;
    nx_epc  = pc;
    if (trap_intr) begin
      nx_tval = '0;
    end else if (brk) begin
      nx_tval = mem_addr;
    end else begin
      case (trap_cause)
        C_BADTGT: begin
          nx_tval = bad_pc;
          nx_epc  = bad_pc;
        end
        C_ILL:    nx_tval = inst_rvc ? XLEN'(inst[15:0]) : XLEN'(inst);
        C_LDMA, C_STMA, C_LDAF, C_STAF: nx_tval = mem_addr;
        C_FETCHAF: nx_tval = pc;
        default:  nx_tval = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_we_m  <= 1'b0;
      out_we_s  <= 1'b0;
      out_we_vs <= 1'b0;
      out_cause <= '0;
      out_tval  <= '0;
      out_epc   <= '0;
    end else begin
      out_we_s  <= trap_fire && (trap_lvl == 2'd1);
      out_we_vs <= trap_fire && (trap_lvl == 2'd2);
      out_we_m  <= trap_fire && ((trap_lvl == 2'd0) || (trap_lvl == 2'd3));
      if (trap_fire) begin
        out_cause <= nx_cause;
        out_tval  <= nx_tval;
        out_epc   <= nx_epc;
      end
    end
  end
endmodule

module trap_value_sel_chk #(
  parameter int XLEN = 64,
  parameter int VAW  = 39,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tgt_bad,
  input logic            trap_fire,
  input logic            trap_intr,
  input logic [CW-1:0]   trap_cause,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] mem_addr,
  input logic            out_we_m,
  input logic            out_we_s,
  input logic            out_we_vs,
  input logic [XLEN-1:0] out_tval,
  input logic [XLEN-1:0] out_epc,
  input logic            held_vld,
  input logic [XLEN-1:0] held_tgt
);
  p_we_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_we_m, out_we_s, out_we_vs}));

  p_we_after_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> $countones({out_we_m, out_we_s, out_we_vs}) == 1);

  p_we_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_fire |=> !(out_we_m || out_we_s || out_we_vs));

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (held_vld && !trap_fire) |=> (held_vld && $stable(held_tgt)));

  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_bad && !held_vld && !trap_fire) |=> held_vld);

  p_badtgt_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_fire && !trap_intr && trap_cause == CW'(1)) |=> (out_tval == out_epc));

  p_intr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_fire && trap_intr) |=> (out_tval == '0 && out_epc == $past(pc)));

  p_fault_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_fire && !trap_intr && (trap_cause == CW'(5) || trap_cause == CW'(6)))
      |=> (out_tval == $past(mem_addr)));
endmodule

bind trap_value_sel trap_value_sel_chk #(.XLEN(XLEN), .VAW(VAW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_bad(tgt_bad), .trap_fire(trap_fire),
  .trap_intr(trap_intr), .trap_cause(trap_cause), .pc(pc), .mem_addr(mem_addr),
  .out_we_m(out_we_m), .out_we_s(out_we_s), .out_we_vs(out_we_vs),
  .out_tval(out_tval), .out_epc(out_epc), .held_vld(held_vld), .held_tgt(held_tgt)
);

// File: tb/trap_value_sel_test.sv
module trap_value_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int VAW  = 39;
  localparam int CW   = 4;

  logic clk = 0, rst_n = 0;
  logic tgt_valid = 0, trap_fire = 0, trap_intr = 0, is_amo = 0, trig_hit = 0, inst_rvc = 0;
  logic [XLEN-1:0] tgt_addr = '0, pc = '0, mem_addr = '0;
  logic [CW-1:0] trap_cause = '0;
  logic [1:0] trap_lvl = '0;
  logic [31:0] inst = '0;
  logic tgt_bad, out_we_m, out_we_s, out_we_vs;
  logic [CW-1:0] out_cause;
  logic [XLEN-1:0] out_tval, out_epc;

  int checks = 0, fails = 0;

  trap_value_sel #(.XLEN(XLEN), .VAW(VAW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tgt_valid(tgt_valid), .tgt_addr(tgt_addr), .tgt_bad(tgt_bad),
    .trap_fire(trap_fire), .trap_intr(trap_intr), .trap_cause(trap_cause), .trap_lvl(trap_lvl),
    .is_amo(is_amo), .trig_hit(trig_hit), .pc(pc), .mem_addr(mem_addr), .inst(inst),
    .inst_rvc(inst_rvc), .out_we_m(out_we_m), .out_we_s(out_we_s), .out_we_vs(out_we_vs),
    .out_cause(out_cause), .out_tval(out_tval), .out_epc(out_epc));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic trap(input logic intr, input logic [CW-1:0] c, input logic [1:0] lvl,
                      input logic amo, input logic trig, input logic rvc);
    @(negedge clk);
    tgt_valid = 0; trap_fire = 1; trap_intr = intr; trap_cause = c; trap_lvl = lvl;
    is_amo = amo; trig_hit = trig; inst_rvc = rvc;
    @(negedge clk);
    trap_fire = 0;
  endtask

  task automatic expect_out(input string req, input logic intr, input logic [CW-1:0] c,
                            input logic [1:0] lvl, input logic amo, input logic trig,
                            input logic rvc, input logic hv, input logic [XLEN-1:0] held);
    logic brk;
    logic [CW-1:0] ec;
    logic [XLEN-1:0] et, ep;
    brk = !intr && trig && (c == 0 || (amo && (c == 3 || c == 4)));
    ec = brk ? CW'(9) : c;
    ep = pc;
    if (intr) et = '0;
    else if (brk) et = mem_addr;
    else case (c)
      1: begin et = hv ? held : pc; ep = et; end
      2: et = rvc ? {48'h0, inst[15:0]} : {32'h0, inst};
      3, 4, 5, 6: et = mem_addr;
      8: et = pc;
      default: et = '0;
    endcase
    chk({req, " tval"}, out_tval, et);
    chk({req, " epc"}, out_epc, ep);
    chk({req, " cause"}, XLEN'(out_cause), XLEN'(ec));
    chk("R11 we", XLEN'({out_we_m, out_we_s, out_we_vs}),
        XLEN'(lvl == 1 ? 3'b010 : lvl == 2 ? 3'b001 : 3'b100));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset we", XLEN'({out_we_m, out_we_s, out_we_vs}), '0);
    chk("R11 reset tval", out_tval, '0);
    rst_n = 1;

    // R1: a target inside the address width is not flagged and not held
    @(negedge clk);
    tgt_valid = 1; tgt_addr = 64'h0000_0040_0000_1000 >> 1; #1;
    chk("R1 good flag", XLEN'(tgt_bad), 0);
    pc = 64'h1234;
    trap(0, 1, 0, 0, 0, 0);
    expect_out("R3 no held", 0, 1, 0, 0, 0, 0, 0, '0);
    @(negedge clk);
    chk("R11 quiet", XLEN'({out_we_m, out_we_s, out_we_vs}), '0);

    for (int i = 0; i < 1024; i++) begin
      logic [CW-1:0] c;
      logic intr, amo, trig, rvc;
      logic [1:0] lvl;
      logic [XLEN-1:0] a, b;
      c = CW'(i); intr = i[4]; amo = i[5]; trig = i[6]; rvc = i[7]; lvl = i[9:8];
      a = (64'h1 << (VAW + (i % 25))) | XLEN'(i * 64'h1111);
      b = a ^ 64'h8000_0000_0000_00F0;
      @(negedge clk);
      tgt_valid = 1; tgt_addr = a; #1;
      chk("R1 bad flag", XLEN'(tgt_bad), 1);
      @(negedge clk);
      tgt_addr = b;
      pc = 64'h8000_0000_0000_0000 | XLEN'(i * 4);
      mem_addr = 64'hABCD_0000_0000_0001 + XLEN'(i * 3);
      inst = 32'hC0DE_0000 ^ (i * 32'h0001_0107);
      trap(intr, c, lvl, amo, trig, rvc);
      if (c == 1 && !intr) expect_out("R2 R3 held", intr, c, lvl, amo, trig, rvc, 1, a);
      else if (intr) expect_out("R8", intr, c, lvl, amo, trig, rvc, 1, a);
      else if (trig && (c == 0 || c == 3 || c == 4)) expect_out("R4 R5", intr, c, lvl, amo, trig, rvc, 1, a);
      else if (c == 2) expect_out(rvc ? "R6" : "R7", intr, c, lvl, amo, trig, rvc, 1, a);
      else if (c >= 3 && c <= 8) expect_out("R9 R12", intr, c, lvl, amo, trig, rvc, 1, a);
      else expect_out("R10", intr, c, lvl, amo, trig, rvc, 1, a);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule